// File: doc/BRIEF.md
# Banked Predictor Update Queue

This block sits on the update path of a value predictor that is split into four independent banks. Retiring loads send one update per cycle. An update carries the load's PC, the value its destination register held, and the value the load actually returned. PC bits [3:2] choose the bank. Because instructions are 4 bytes and fetch groups are 16 bytes, the loads of one aligned fetch group always land in different banks. Each bank holds its pending updates in its own 16-entry FIFO.

A bank takes an update from its FIFO only in a cycle when it is not busy with a prediction lookup. A lookup request on a bank always wins over a queued update for that bank. An update that arrives at a full FIFO is not applied: it is discarded, and a per-bank saturating counter records the loss. The upstream producer is never stalled.

Top module: `upd_queue_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, no bank output is valid and every drop counter reads zero.
- R2: An update is steered to the bank whose index equals PC bits [3:2]. No other bank ever presents it.
- R3: Updates to one bank are presented to that bank in the order they arrived, with the PC, register value and true value unchanged.
- R4: A bank's update output is never valid in a cycle when that bank's lookup input is high.
- R5: A bank whose queue is non-empty and whose lookup input is low presents exactly one update, the oldest, that cycle. That update is removed at the next clock edge.
- R6: Each bank's queue holds at most 16 pending updates.
- R7: Each discarded update increments its bank's drop counter by one. The counter saturates at its all-ones value.
- R8: An update accepted at a clock edge can be presented no earlier than the cycle that follows that edge.
- R9: Fullness is judged on the occupancy before that cycle's pop. An update that arrives at a full queue is discarded even when the queue pops an entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | An update is offered this cycle |
| upd_pc_i | input | 32 | PC of the updating load; bits [3:2] select the bank |
| upd_reg_i | input | 64 | Destination register value before the load |
| upd_val_i | input | 64 | True loaded value |
| lookup_i | input | NUM_BANKS | Per-bank prediction lookup in progress |
| bank_valid_o | output | NUM_BANKS | Per-bank update presented this cycle |
| bank_pc_o | output | NUM_BANKS x 32 | PC of the presented update |
| bank_reg_o | output | NUM_BANKS x 64 | Register value of the presented update |
| bank_val_o | output | NUM_BANKS x 64 | True value of the presented update |
| drop_cnt_o | output | NUM_BANKS x DROP_W | Per-bank count of discarded updates |

## Verification
A pushed update is written at the clock edge that follows the cycle it was offered. It shows up on its bank's outputs in the next cycle at the earliest. Bank valid responds to lookup_i combinationally within the same cycle. A drop counter changes at the edge that ends the rejecting cycle. The bench drives inputs just after each falling edge, samples every output one time unit later against a queue model, and advances that model exactly once per rising edge, so each expected value is compared in the cycle it is due.

// File: rtl/upq_pkg.sv
package upq_pkg;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned DATA_W = 64;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] reg_val;
    logic [DATA_W-1:0] true_val;
  } upd_t;
endpackage

// File: rtl/upq_fifo.sv
module upq_fifo
  import upq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  upd_t          din_i,
  input  logic          pop_i,
  output upd_t          head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  upd_t          mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wrap_inc(wr_q);
      if (pop_ok)  rd_q <= wrap_inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/upq_sat_cnt.sv
module upq_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (inc_i && cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/upd_queue_bank.sv
module upd_queue_bank
  import upq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DROP_W    = 8,
  parameter int unsigned BANK_LSB  = 2,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                upd_valid_i,
  input  logic [PC_W-1:0]                     upd_pc_i,
  input  logic [DATA_W-1:0]                   upd_reg_i,
  input  logic [DATA_W-1:0]                   upd_val_i,
  input  logic [NUM_BANKS-1:0]                lookup_i,
  output logic [NUM_BANKS-1:0]                bank_valid_o,
  output logic [NUM_BANKS-1:0][PC_W-1:0]      bank_pc_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_reg_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_val_o,
  output logic [NUM_BANKS-1:0][DROP_W-1:0]    drop_cnt_o
);
  logic [BANK_W-1:0]               sel;
  upd_t                            din;
  logic [NUM_BANKS-1:0][CNT_W-1:0] occ;

  assign sel = upd_pc_i[BANK_LSB +: BANK_W];
  assign din = '{pc: upd_pc_i, reg_val: upd_reg_i, true_val: upd_val_i};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic push, pop, empty, full;
    upd_t head;

    assign push = upd_valid_i && (sel == BANK_W'(b));
    // lookup owns the bank port this cycle
    assign pop  = !empty && !lookup_i[b];

    upq_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push),
      .din_i   (din),
      .pop_i   (pop),
      .head_o  (head),
      .empty_o (empty),
      .full_o  (full),
      .cnt_o   (occ[b])
    );

    upq_sat_cnt #(.W(DROP_W)) u_drop (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (push && full),
      .cnt_o  (drop_cnt_o[b])
    );

    assign bank_valid_o[b] = pop;
    assign bank_pc_o[b]    = head.pc;
    assign bank_reg_o[b]   = head.reg_val;
    assign bank_val_o[b]   = head.true_val;
  end
endmodule

// File: rtl/upq_chk.sv
module upq_chk #(
  parameter int unsigned NB     = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DROP_W = 8,
  parameter int unsigned CNT_W  = 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NB-1:0]              lookup_i,
  input logic [NB-1:0]              bank_valid_i,
  input logic [NB-1:0][DROP_W-1:0]  drop_i,
  input logic [NB-1:0][CNT_W-1:0]   occ_i
);
  for (genvar b = 0; b < NB; b++) begin : g_chk
    assert_lookup_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_valid_i[b] |-> !lookup_i[b]);
    assert_idle_drains_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ_i[b] != '0 && !lookup_i[b]) |-> bank_valid_i[b]);
    assert_pop_shrinks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_valid_i[b] |=> occ_i[b] <= $past(occ_i[b]));
    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_i[b] <= CNT_W'(DEPTH));
    assert_drop_saturates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_i[b] == '1 |=> drop_i[b] == '1);
    assert_drop_when_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(drop_i[b]) |-> $past(occ_i[b]) == CNT_W'(DEPTH));
  end
endmodule

bind upd_queue_bank upq_chk #(
  .NB(NUM_BANKS), .DEPTH(DEPTH), .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_i     (lookup_i),
  .bank_valid_i (bank_valid_o),
  .drop_i       (drop_cnt_o),
  .occ_i        (occ)
);

// File: tb/upd_queue_bank_bench.sv
module upd_queue_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int QD = 16;
  localparam int DW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic [63:0] upd_reg_i = '0, upd_val_i = '0;
  logic [NB-1:0] lookup_i = '0;
  logic [NB-1:0] bank_valid_o;
  logic [NB-1:0][31:0] bank_pc_o;
  logic [NB-1:0][63:0] bank_reg_o, bank_val_o;
  logic [NB-1:0][DW-1:0] drop_cnt_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_pc [NB][QD];
  logic [63:0] m_rg [NB][QD];
  logic [63:0] m_vl [NB][QD];
  int m_head [NB], m_cnt [NB], m_drop [NB];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  upd_queue_bank #(.DROP_W(DW)) u_upd_queue_bank (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_pc(int seq, int bank);
    return 32'((seq << 4) | (bank << 2));
  endfunction

  task automatic step(input bit v, input int bank, input int seq, input logic [NB-1:0] lk);
    logic [31:0] pc = mk_pc(seq, bank);
    logic [63:0] rg = {32'hA5A50000 | 32'(seq), 32'(seq * 3)};
    logic [63:0] vl = {32'(seq), ~32'(seq)};
    bit ev [NB];
    upd_valid_i = v; upd_pc_i = pc; upd_reg_i = rg; upd_val_i = vl; lookup_i = lk;
    #1;
    for (int b = 0; b < NB; b++) begin
      ev[b] = (m_cnt[b] > 0) && !lk[b];
      chk(bank_valid_o[b] == ev[b], "R4/R8/R2 valid", 64'(bank_valid_o[b]), 64'(ev[b]));
      if (ev[b]) begin
        chk(bank_pc_o[b] == m_pc[b][m_head[b]], "R2/R3/R5 pc", 64'(bank_pc_o[b]), 64'(m_pc[b][m_head[b]]));
        chk(bank_reg_o[b] == m_rg[b][m_head[b]], "R3 reg", bank_reg_o[b], m_rg[b][m_head[b]]);
        chk(bank_val_o[b] == m_vl[b][m_head[b]], "R3 val", bank_val_o[b], m_vl[b][m_head[b]]);
      end
      chk(drop_cnt_o[b] == DW'(m_drop[b]), "R6/R7/R9 drop", 64'(drop_cnt_o[b]), 64'(m_drop[b]));
    end
    for (int b = 0; b < NB; b++) begin
      bit full_pre = (m_cnt[b] == QD);
      if (ev[b]) begin m_head[b] = (m_head[b] + 1) % QD; m_cnt[b]--; end
      if (v && bank == b) begin
        if (full_pre) begin
          if (m_drop[b] < (1 << DW) - 1) m_drop[b]++;
        end else begin
          int w = (m_head[b] + m_cnt[b]) % QD;
          m_pc[b][w] = pc; m_rg[b][w] = rg; m_vl[b][w] = vl; m_cnt[b]++;
        end
      end
    end
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    int seq = 1;
    for (int b = 0; b < NB; b++) begin m_head[b] = 0; m_cnt[b] = 0; m_drop[b] = 0; end
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state
    chk(bank_valid_o == '0, "R1 valid", 64'(bank_valid_o), 0);
    chk(drop_cnt_o == '0, "R1 drop", 64'(drop_cnt_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, '0);
    // R6: overflow bank 0 while lookups hold it
    for (int i = 0; i < 20; i++) step(1, 0, seq++, 4'b0001);
    // R9: full and popping, incoming still dropped
    step(1, 0, seq++, 4'b0000);
    for (int i = 0; i < 20; i++) step(0, 0, 0, '0);
    // sweep of bank and lookup patterns
    for (int i = 0; i < 600; i++) begin
      int bk = (i * 3 + i / 5) % NB;
      bit v = (i % 7) != 6;
      logic [NB-1:0] lk = NB'((i * 5) ^ (i / 3));
      if ((i / 100) % 2 == 1) lk = lk | 4'b0110;
      step(v, bk, seq++, lk);
    end
    // R7: saturate bank 3
    for (int i = 0; i < 40; i++) step(1, 3, seq++, 4'b1000);
    for (int i = 0; i < 40; i++) step(0, 0, 0, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule